// File: doc/BRIEF.md
# Selectable-Period Watchdog Reset Generator

This block watches a host for regular service strobes and pulls an active-low reset output down when the host goes quiet for too long. The allowed silence is set by a 2-bit period code, which a register block elsewhere in the chip supplies. Three codes pick one of three timeouts, each given as a clock-cycle count through parameters. The fourth code switches the timeout off completely. A digital supply-low flag also forces reset, and so does a fixed hold interval that follows power-on.

A timeout produces a reset pulse of a fixed length in cycles. After the pulse, the watchdog starts a new full period. Any of the following starts the count over: a service strobe, a change of period code, a high supply-low flag, or entry into the counting state. The supply-low flag drives the output through logic only, with no register in the path, so reset follows the flag in the same cycle. The power-on reset input is asserted asynchronously and released through a two-flop synchronizer.

Top module: `wdt_reset_gen`

## Requirements
- R1: While rst_n is low, reset_n_out is low. After rst_n rises, reset_n_out stays low and rises on the (PWRUP_CYC+2)-th rising clock edge: two edges for the release synchronizer, then PWRUP_CYC edges of hold.
- R2: With period code 2'b00, reset_n_out falls on the TO_LONG_CYC-th rising edge after the last restart edge.
- R3: With code 2'b01 the timeout is TO_MID_CYC edges. With code 2'b10 it is TO_SHORT_CYC edges. Both are counted from the last restart edge.
- R4: Code 2'b11 disables the watchdog. While the code stays at 2'b11, no timeout ever drives reset_n_out low.
- R5: A kick sampled high at a rising edge makes that edge a restart edge. Kicking more often than the period keeps reset_n_out high.
- R6: An edge at which period_sel differs from its value at the previous edge is a restart edge, and the new code's period then applies.
- R7: A timeout holds reset_n_out low for exactly PULSE_CYC cycles. After the pulse the output returns high and a full new period is counted.
- R8: reset_n_out is low in the same cycle that supply_low is high. Every edge at which supply_low is high is a restart edge, so after supply_low falls a full period passes before a timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| supply_low | input | 1 | Supply below trip point, forces reset |
| kick | input | 1 | Service strobe from the host |
| period_sel | input | 2 | Period code: 00 long, 01 mid, 10 short, 11 off |
| reset_n_out | output | 1 | Generated reset, active low |

## Verification
A counter that is not cleared on a kick, a code change or supply-low shows up as a reset edge that comes too early. The short period exposes this within a dozen cycles of the restart. A wrong decode of the period code changes the measured high-run length on the very next timeout. A mismatched hold counter changes the low-run length of either the power-up interval or the timeout pulse. A state machine stuck outside the counting state leaves the output low past the expected release edge. The bench therefore measures the exact length of every high and low run in clock cycles and compares it with the value the requirements give.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2
  } wdt_state_e;

  localparam logic [1:0] CODE_LONG  = 2'b00;
  localparam logic [1:0] CODE_MID   = 2'b01;
  localparam logic [1:0] CODE_SHORT = 2'b10;
  localparam logic [1:0] CODE_OFF   = 2'b11;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/wdt_period_decode.sv
module wdt_period_decode
  import wdt_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int TO_LONG_CYC  = 140,
  parameter int TO_MID_CYC   = 60,
  parameter int TO_SHORT_CYC = 20
) (
  input  logic [1:0]       code,
  output logic [CNT_W-1:0] limit,
  output logic             off
);
  always_comb begin
    off   = 1'b0;
    limit = CNT_W'(TO_LONG_CYC);
    case (code)
      CODE_LONG:  limit = CNT_W'(TO_LONG_CYC);
      CODE_MID:   limit = CNT_W'(TO_MID_CYC);
      CODE_SHORT: limit = CNT_W'(TO_SHORT_CYC);
      default:    off   = 1'b1;
    endcase
  end
endmodule

// File: rtl/wdt_cycle_counter.sv
module wdt_cycle_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         wrap,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)       cnt_d = '0;
    else if (en)   cnt_d = wrap ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen
  import wdt_pkg::*;
#(
  parameter int TO_LONG_CYC  = 1400,
  parameter int TO_MID_CYC   = 600,
  parameter int TO_SHORT_CYC = 200,
  parameter int PWRUP_CYC    = 100,
  parameter int PULSE_CYC    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_low,
  input  logic       kick,
  input  logic [1:0] period_sel,
  output logic       reset_n_out
);
  localparam int MAX_TO = (TO_LONG_CYC > TO_MID_CYC)
                        ? ((TO_LONG_CYC > TO_SHORT_CYC) ? TO_LONG_CYC : TO_SHORT_CYC)
                        : ((TO_MID_CYC > TO_SHORT_CYC) ? TO_MID_CYC : TO_SHORT_CYC);
  localparam int MAX_HOLD = (PWRUP_CYC > PULSE_CYC) ? PWRUP_CYC : PULSE_CYC;
  localparam int CNT_W    = $clog2(MAX_TO + 1);
  localparam int HOLD_W   = $clog2(MAX_HOLD + 1);

  logic              rst_sync_n;
  wdt_state_e        state_q, state_d;
  logic [1:0]        period_q;
  logic [CNT_W-1:0]  wd_limit, wd_cnt;
  logic              wd_off, wd_en, wd_clr, wd_hit, timeout;
  logic [HOLD_W-1:0] hold_limit, hold_cnt;
  logic              hold_en, hold_clr, hold_hit;

  wdt_rst_sync u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  wdt_period_decode #(
    .CNT_W        (CNT_W),
    .TO_LONG_CYC  (TO_LONG_CYC),
    .TO_MID_CYC   (TO_MID_CYC),
    .TO_SHORT_CYC (TO_SHORT_CYC)
  ) u_dec (
    .code  (period_sel),
    .limit (wd_limit),
    .off   (wd_off)
  );

  // Timeout counter: only advances in the counting state
  assign wd_en   = (state_q == ST_RUN);
  assign wd_clr  = !wd_en || supply_low || kick || (period_sel != period_q) || wd_off;
  assign wd_hit  = (wd_cnt == wd_limit - CNT_W'(1));
  assign timeout = wd_en && !wd_clr && wd_hit;

  wdt_cycle_counter #(.W(CNT_W)) u_wd_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (wd_clr),
    .en    (wd_en),
    .wrap  (wd_hit),
    .cnt   (wd_cnt)
  );

  // Hold counter: shared by the power-up interval and the timeout pulse
  assign hold_en    = (state_q != ST_RUN);
  assign hold_clr   = (state_q == ST_RUN);
  assign hold_limit = (state_q == ST_PWRUP) ? HOLD_W'(PWRUP_CYC) : HOLD_W'(PULSE_CYC);
  assign hold_hit   = (hold_cnt == hold_limit - HOLD_W'(1));

  wdt_cycle_counter #(.W(HOLD_W)) u_hold_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (hold_clr),
    .en    (hold_en),
    .wrap  (hold_hit),
    .cnt   (hold_cnt)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PWRUP: if (hold_hit) state_d = ST_RUN;
      ST_RUN:   if (timeout)  state_d = ST_PULSE;
      ST_PULSE: if (hold_hit) state_d = ST_RUN;
      default:  state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_PWRUP;
      period_q <= CODE_LONG;
    end else begin
      state_q  <= state_d;
      period_q <= period_sel;
    end
  end

  assign reset_n_out = (state_q == ST_RUN) && !supply_low;
endmodule

// File: rtl/wdt_reset_gen_checker.sv
module wdt_reset_gen_checker
  import wdt_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int HOLD_W       = 8,
  parameter int TO_LONG_CYC  = 1400,
  parameter int TO_MID_CYC   = 600,
  parameter int TO_SHORT_CYC = 200,
  parameter int PWRUP_CYC    = 100,
  parameter int PULSE_CYC    = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              supply_low,
  input logic              kick,
  input logic [1:0]        period_sel,
  input logic              reset_n_out,
  input wdt_state_e        state_q,
  input logic [1:0]        period_q,
  input logic [CNT_W-1:0]  wd_cnt,
  input logic [HOLD_W-1:0] hold_cnt
);
  function automatic logic [CNT_W-1:0] exp_last(input logic [1:0] c);
    case (c)
      CODE_LONG:  return CNT_W'(TO_LONG_CYC - 1);
      CODE_MID:   return CNT_W'(TO_MID_CYC - 1);
      default:    return CNT_W'(TO_SHORT_CYC - 1);
    endcase
  endfunction

  // R1: counting begins only after the full power-up hold
  assert_pwrup_len_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(state_q) == ST_PWRUP && state_q == ST_RUN) |-> $past(hold_cnt) == HOLD_W'(PWRUP_CYC - 1));

  // R2, R3: a timeout fires only when the count reaches the selected period
  assert_timeout_limit_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(state_q) == ST_RUN && state_q == ST_PULSE) |-> $past(wd_cnt) == exp_last($past(period_q)));

  // R4: the counter stays idle while the off code is in force
  assert_off_idle_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (period_q == CODE_OFF) |-> wd_cnt == '0);

  // R5: a kick restarts the count
  assert_kick_clear_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kick |=> wd_cnt == '0);

  // R6: a code change restarts the count
  assert_code_change_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (period_sel != period_q) |=> wd_cnt == '0);

  // R7: the timeout pulse lasts the full pulse length
  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(state_q) == ST_PULSE && state_q == ST_RUN) |-> $past(hold_cnt) == HOLD_W'(PULSE_CYC - 1));

  // R8: supply-low keeps the counter cleared and reset asserted
  assert_supply_clear_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    supply_low |=> wd_cnt == '0);

  assert_supply_out_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    supply_low |-> !reset_n_out);
endmodule

bind wdt_reset_gen wdt_reset_gen_checker #(
  .CNT_W        (CNT_W),
  .HOLD_W       (HOLD_W),
  .TO_LONG_CYC  (TO_LONG_CYC),
  .TO_MID_CYC   (TO_MID_CYC),
  .TO_SHORT_CYC (TO_SHORT_CYC),
  .PWRUP_CYC    (PWRUP_CYC),
  .PULSE_CYC    (PULSE_CYC)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .supply_low  (supply_low),
  .kick        (kick),
  .period_sel  (period_sel),
  .reset_n_out (reset_n_out),
  .state_q     (state_q),
  .period_q    (period_q),
  .wd_cnt      (wd_cnt),
  .hold_cnt    (hold_cnt)
);

// File: tb/wdt_reset_gen_bench.sv
module wdt_reset_gen_bench;
  localparam int LONG_C  = 60;
  localparam int MID_C   = 30;
  localparam int SHORT_C = 12;
  localparam int PWR_C   = 10;
  localparam int PUL_C   = 5;

  logic       clk;
  logic       rst_n;
  logic       supply_low;
  logic       kick;
  logic [1:0] period_sel;
  logic       reset_n_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  wdt_reset_gen #(
    .TO_LONG_CYC  (LONG_C),
    .TO_MID_CYC   (MID_C),
    .TO_SHORT_CYC (SHORT_C),
    .PWRUP_CYC    (PWR_C),
    .PULSE_CYC    (PUL_C)
  ) u_wdt_reset_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_low  (supply_low),
    .kick        (kick),
    .period_sel  (period_sel),
    .reset_n_out (reset_n_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count consecutive high samples, starting with the current negedge
  task automatic count_high(output int n);
    n = 0;
    forever begin
      #1;
      if (!reset_n_out || n > 1000) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_low(output int n);
    n = 0;
    forever begin
      #1;
      if (reset_n_out || n > 1000) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_high(input int cyc, input string req);
    int lows = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); #1;
      if (!reset_n_out) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  task automatic test_powerup();
    int n;
    rst_n = 1'b0; supply_low = 1'b0; kick = 1'b0; period_sel = 2'b10;
    repeat (3) @(negedge clk);
    #1 check(reset_n_out == 1'b0, "R1 reset state", reset_n_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    count_low(n);
    check(n == PWR_C + 1, "R1 power-up hold", n, PWR_C + 1);
    count_high(n);
    check(n == SHORT_C, "R3 short period code 10", n, SHORT_C);
  endtask

  task automatic test_pulse();
    int n;
    count_low(n);
    check(n == PUL_C, "R7 pulse width", n, PUL_C);
    count_high(n);
    check(n == SHORT_C, "R7 full period after pulse", n, SHORT_C);
    count_low(n);
  endtask

  task automatic test_kick();
    int n;
    for (int i = 0; i < 5; i++) begin
      repeat (SHORT_C - 4) begin
        @(negedge clk); #1;
        check(reset_n_out == 1'b1, "R5 kicks keep reset high", reset_n_out, 1);
      end
      @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
    end
    count_high(n);
    check(n == SHORT_C, "R5 period after last kick", n, SHORT_C);
    count_low(n);
  endtask

  task automatic test_codes();
    int n;
    repeat (3) @(negedge clk);
    period_sel = 2'b01;
    @(negedge clk);
    count_high(n);
    check(n == MID_C, "R3 R6 code 01 after change", n, MID_C);
    count_low(n);
    repeat (3) @(negedge clk);
    period_sel = 2'b00;
    @(negedge clk);
    count_high(n);
    check(n == LONG_C, "R2 R6 code 00 after change", n, LONG_C);
    count_low(n);
  endtask

  task automatic test_off();
    int n;
    @(negedge clk);
    period_sel = 2'b11;
    wait_high(3 * LONG_C, "R4 code 11 never times out");
    @(negedge clk);
    period_sel = 2'b10;
    @(negedge clk);
    count_high(n);
    check(n == SHORT_C, "R6 leaving code 11", n, SHORT_C);
    count_low(n);
  endtask

  task automatic test_supply();
    int n;
    int highs = 0;
    repeat (3) @(negedge clk);
    supply_low = 1'b1;
    #1 check(reset_n_out == 1'b0, "R8 immediate reset", reset_n_out, 0);
    for (int i = 0; i < 3 * SHORT_C; i++) begin
      @(negedge clk); #1;
      if (reset_n_out) highs++;
    end
    check(highs == 0, "R8 reset held while supply low", highs, 0);
    @(negedge clk);
    supply_low = 1'b0;
    #1 check(reset_n_out == 1'b1, "R8 release on supply recovery", reset_n_out, 1);
    @(negedge clk);
    count_high(n);
    check(n == SHORT_C - 1, "R8 full period after supply low", n + 1, SHORT_C);
  endtask

  initial begin
    test_powerup();
    test_pulse();
    test_kick();
    test_codes();
    test_off();
    test_supply();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule